// File: doc/BRIEF.md
# Dual-Rank Channel Code Bank

This block keeps eight 10-bit converter codes in two ranks of registers. The bus engine writes the storage rank one word at a time. The active rank drives the converter outputs. Because the ranks are separate, a whole new set of codes can be loaded into storage ahead of time and then made visible on every output at once.

There are three ways to move storage into the active rank:
- **Transparent mode.** While the external load pin is low, a write to storage also updates that channel's active register.
- **Pin release.** When the load pin goes from high to low, all eight active registers load together in a single cycle.
- **Software flag.** An update flag on a written word copies all of storage into the active rank, whatever the pin level.

Reset commands set channels back to mid-scale. They come from the power-up reset, from a general-call reset request, or from pointer-byte codes that name either every channel or a single channel. A read-back port returns the storage value of any channel.

Top module: `dual_rank_code_bank`

## Requirements
- R1: While `rst_n` is low, every storage and active register holds mid-scale code 512. They hold 512 after release until something changes them.
- R2: A `genResetReq` pulse sets every storage and active register to 512 at that clock edge. It does this whatever the load pin level and whatever write is offered in the same cycle.
- R3: The load pin passes through two synchronizer flops. While the synchronized level is low, a write (`wrValid`) updates storage and active for channel `wrChan` at the same edge.
- R4: While the synchronized pin level is high, a write without the update flag changes storage only. The active rank keeps its values.
- R5: A high-to-low change of the pin loads every active register from storage at one edge: the third rising edge after the pin changes.
- R6: A write with `wrUpdate` set writes storage and then loads all eight active registers from storage at that same edge, including the word just written. This happens even while the pin is high.
- R7: A pointer strobe whose `ptrByte` bits 7:5 equal 3'b100 sets all storage and active registers to 512 at that edge, whatever the pin level.
- R8: A pointer strobe whose bits 7:5 equal 3'b010 and whose bits 4:0 hold a channel index below 8 sets only that channel's storage and active registers to 512. All other channels are left as they were.
- R9: A pointer strobe with any other bits 7:5 code, or with code 3'b010 and an index of 8 or more, changes no register.
- R10: `rdData` shows, without a clock, the storage value of channel `rdChan`, not its active value.
- R11: When a pointer reset and a write hit the same channel in one cycle, the reset wins and both registers of that channel read 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| loadPin | input | 1 | External load pin, asynchronous to `clk` |
| genResetReq | input | 1 | General-call reset request, one-cycle strobe |
| wrValid | input | 1 | Completed 16-bit data word strobe |
| wrChan | input | 3 | Channel index of the written word |
| wrData | input | 10 | Code of the written word |
| wrUpdate | input | 1 | Update flag (bit 15) of the written word |
| ptrValid | input | 1 | Pointer byte strobe |
| ptrByte | input | 8 | Pointer byte: bits 7:5 command code, bits 4:0 channel index |
| rdChan | input | 3 | Read-back channel select |
| rdData | output | 10 | Storage code of `rdChan` |
| activeFlat | output | 80 | Active codes; channel i at bits [i*10 +: 10] |

## Verification
If a storage register is corrupted, `rdData` shows the fault as soon as that channel is selected. The fault also reaches `activeFlat` at the next load-all or transparent write. If an active register is corrupted, or the pin-edge detector fires wrongly or not at all, `activeFlat` differs from the expected value one edge after the event. The bench compares all eight active codes and the selected read-back code against a behavioural model after every clock. A mistimed synchronizer or a missed transfer therefore fails in the cycle it occurs.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int IDX_W = 5;

  typedef struct packed {
    logic             clearAll;
    logic             clearOne;
    logic [IDX_W-1:0] clearIdx;
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic             loadAll;
    logic             passThru;
  } bank_strobe_t;
endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bank_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            loadPin,
  input  logic            genResetReq,
  input  logic            wrValid,
  input  logic [CH_W-1:0] wrChan,
  input  logic            wrUpdate,
  input  logic            ptrValid,
  input  logic [7:0]      ptrByte,
  output bank_strobe_t    ctrl
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevLvl;
  logic                   loadLvl;
  logic                   fallPulse;
  logic [2:0]             ptrCode;
  logic                   idxInRange;

  // Pin synchronizer and previous-level flop.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ   <= '0;
      prevLvl <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], loadPin};
      prevLvl <= loadLvl;
    end
  end

  assign loadLvl    = syncQ[SYNC_STAGES-1];
  assign fallPulse  = prevLvl & ~loadLvl;
  assign ptrCode    = ptrByte[7:5];
  assign idxInRange = int'(ptrByte[4:0]) < NUM_CH;

  always_comb begin
    ctrl          = '0;
    ctrl.clearAll = genResetReq | (ptrValid & (ptrCode == 3'b100));
    ctrl.clearOne = ptrValid & (ptrCode == 3'b010) & idxInRange;
    ctrl.clearIdx = ptrByte[4:0];
    ctrl.wrEn     = wrValid;
    ctrl.wrIdx    = IDX_W'(wrChan);
    ctrl.loadAll  = fallPulse | (wrValid & wrUpdate);
    ctrl.passThru = ~loadLvl;
  end
endmodule

// File: rtl/bank_regs.sv
module bank_regs
  import bank_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int CODE_W  = 10,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int FLAT_W = NUM_CH * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_strobe_t      ctrl,
  input  logic [CODE_W-1:0] wrData,
  input  logic [CH_W-1:0]   rdChan,
  output logic [CODE_W-1:0] rdData,
  output logic [FLAT_W-1:0] activeFlat,
  output logic [FLAT_W-1:0] storeFlat
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] storeQ [NUM_CH];
  logic [CODE_W-1:0] actQ   [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic wrHit;
    logic clrHit;
    assign wrHit  = ctrl.wrEn & (ctrl.wrIdx == IDX_W'(i));
    assign clrHit = ctrl.clearAll | (ctrl.clearOne & (ctrl.clearIdx == IDX_W'(i)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        storeQ[i] <= MID;
        actQ[i]   <= MID;
      end else if (clrHit) begin
        storeQ[i] <= MID;
        actQ[i]   <= MID;
      end else begin
        if (wrHit) storeQ[i] <= wrData;
        if (ctrl.loadAll) actQ[i] <= wrHit ? wrData : storeQ[i];
        else if (ctrl.passThru && wrHit) actQ[i] <= wrData;
      end
    end

    assign activeFlat[i*CODE_W +: CODE_W] = actQ[i];
    assign storeFlat[i*CODE_W +: CODE_W]  = storeQ[i];
  end

  assign rdData = storeQ[rdChan];
endmodule

// File: rtl/dual_rank_code_bank.sv
module dual_rank_code_bank
  import bank_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int CODE_W      = 10,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = $clog2(NUM_CH),
  localparam int FLAT_W     = NUM_CH * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadPin,
  input  logic              genResetReq,
  input  logic              wrValid,
  input  logic [CH_W-1:0]   wrChan,
  input  logic [CODE_W-1:0] wrData,
  input  logic              wrUpdate,
  input  logic              ptrValid,
  input  logic [7:0]        ptrByte,
  input  logic [CH_W-1:0]   rdChan,
  output logic [CODE_W-1:0] rdData,
  output logic [FLAT_W-1:0] activeFlat
);
  bank_strobe_t      ctrl;
  logic [FLAT_W-1:0] storeFlat;

  bank_ctrl #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .loadPin(loadPin), .genResetReq(genResetReq),
    .wrValid(wrValid), .wrChan(wrChan), .wrUpdate(wrUpdate),
    .ptrValid(ptrValid), .ptrByte(ptrByte), .ctrl(ctrl)
  );

  bank_regs #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .wrData(wrData), .rdChan(rdChan),
    .rdData(rdData), .activeFlat(activeFlat), .storeFlat(storeFlat)
  );
endmodule

// File: rtl/code_bank_checker.sv
module code_bank_checker
  import bank_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int CODE_W  = 10,
  localparam int FLAT_W = NUM_CH * CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              genResetReq,
  input logic              ptrValid,
  input logic [2:0]        ptrCode,
  input logic [CODE_W-1:0] wrData,
  input bank_strobe_t      ctrl,
  input logic [FLAT_W-1:0] activeFlat,
  input logic [FLAT_W-1:0] storeFlat
);
  localparam logic [CODE_W-1:0] MID    = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [FLAT_W-1:0] ALLMID = {NUM_CH{MID}};

  assert_gen_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    genResetReq |=> (activeFlat == ALLMID) && (storeFlat == ALLMID));

  assert_ptr_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptrValid && ptrCode == 3'b100) |=> (activeFlat == ALLMID) && (storeFlat == ALLMID));

  assert_ptr_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.clearOne |=> activeFlat[int'($past(ctrl.clearIdx))*CODE_W +: CODE_W] == MID);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.passThru && !ctrl.loadAll && !ctrl.clearAll && !ctrl.clearOne) |=> $stable(activeFlat));

  assert_load_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.loadAll && !ctrl.clearAll && !ctrl.clearOne) |=> activeFlat == storeFlat); // also R6

  assert_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.passThru && ctrl.wrEn && !ctrl.clearAll && !ctrl.clearOne)
      |=> activeFlat[int'($past(ctrl.wrIdx))*CODE_W +: CODE_W] == $past(wrData));
endmodule

bind dual_rank_code_bank code_bank_checker #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .genResetReq(genResetReq), .ptrValid(ptrValid),
  .ptrCode(ptrByte[7:5]), .wrData(wrData), .ctrl(ctrl),
  .activeFlat(activeFlat), .storeFlat(storeFlat)
);

// File: tb/dual_rank_code_bank_tb.sv
module dual_rank_code_bank_tb_top;
  localparam int N = 8;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         loadPin = 1'b0, genResetReq = 1'b0, wrValid = 1'b0, wrUpdate = 1'b0, ptrValid = 1'b0;
  logic [2:0]   wrChan = '0, rdChan = '0;
  logic [W-1:0] wrData = '0;
  logic [7:0]   ptrByte = '0;
  logic [W-1:0] rdData;
  logic [N*W-1:0] activeFlat;

  dual_rank_code_bank dut_i (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string curReq = "R1";
  bit checkOn = 1'b0;

  // Behavioural reference model.
  int mStore[N], mAct[N];
  int pipe0 = 0, pipe1 = 0, prevLvl = 0;

  task automatic modelReset();
    for (int i = 0; i < N; i++) begin mStore[i] = 512; mAct[i] = 512; end
    pipe0 = 0; pipe1 = 0; prevLvl = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) modelReset();
    else begin
      int lvl, fall, ch;
      lvl = pipe1;
      fall = (prevLvl == 1 && lvl == 0);
      prevLvl = lvl; pipe1 = pipe0; pipe0 = loadPin;
      ch = wrChan;
      if (genResetReq) begin
        for (int i = 0; i < N; i++) begin mStore[i] = 512; mAct[i] = 512; end
      end else begin
        if (wrValid) mStore[ch] = wrData;
        if (fall || (wrValid && wrUpdate)) begin
          for (int i = 0; i < N; i++) mAct[i] = mStore[i];
        end else if (lvl == 0 && wrValid) mAct[ch] = wrData;
        if (ptrValid && ptrByte[7:5] == 3'b100) begin
          for (int i = 0; i < N; i++) begin mStore[i] = 512; mAct[i] = 512; end
        end else if (ptrValid && ptrByte[7:5] == 3'b010 && ptrByte[4:0] < 5'd8) begin
          mStore[ptrByte[2:0]] = 512; mAct[ptrByte[2:0]] = 512;
        end
      end
    end
  end

  task automatic checkVal(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison, away from the edges.
  always @(negedge clk) begin
    #1;
    if (checkOn) begin
      for (int i = 0; i < N; i++)
        checkVal(curReq, $sformatf("active ch%0d", i), int'(activeFlat[i*W +: W]), mAct[i]);
      checkVal(curReq, "rdData (R10)", int'(rdData), mStore[rdChan]);
    end
  end

  always @(posedge clk) if (cycles > 50000) begin
    errors++;
    $display("FAIL watchdog actual=%0d expected<=50000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int ch, int data, bit upd);
    wrValid = 1'b1; wrChan = 3'(ch); wrData = W'(data); wrUpdate = upd;
    cyc();
    wrValid = 1'b0; wrUpdate = 1'b0;
  endtask

  task automatic ptr(logic [7:0] b);
    ptrValid = 1'b1; ptrByte = b;
    cyc();
    ptrValid = 1'b0;
  endtask

  function automatic int actOf(int ch);
    return int'(activeFlat[ch*W +: W]);
  endfunction

  initial begin
    cyc(3);
    curReq = "R1";
    checkVal("R1", "active ch0 in reset", actOf(0), 512);
    rst_n = 1'b1;
    checkOn = 1'b1;
    cyc(4);
    checkVal("R1", "active ch7 after reset", actOf(7), 512);

    // R3 transparent writes with pin low
    curReq = "R3";
    for (int i = 0; i < N; i++) wr(i, 100 + i * 37, 1'b0);
    cyc();
    checkVal("R3", "active ch2 transparent", actOf(2), 174);

    // R10 read-back sweep
    curReq = "R10";
    for (int i = 0; i < N; i++) begin rdChan = 3'(i); cyc(); end

    // R4 hold while pin high
    curReq = "R4";
    loadPin = 1'b1; cyc(4);
    wr(3, 1000, 1'b0); wr(5, 7, 1'b0);
    cyc();
    checkVal("R4", "active ch3 held", actOf(3), 211);
    rdChan = 3'd3; cyc();
    checkVal("R10", "rdData shows storage", int'(rdData), 1000);

    // R5 pin release loads all on the third edge
    curReq = "R5";
    loadPin = 1'b0;
    cyc(2);
    checkVal("R5", "active ch3 before transfer", actOf(3), 211);
    cyc();
    checkVal("R5", "active ch3 after transfer", actOf(3), 1000);
    checkVal("R5", "active ch5 after transfer", actOf(5), 7);

    // R6 software update with pin high
    curReq = "R6";
    loadPin = 1'b1; cyc(4);
    wr(1, 555, 1'b0);
    wr(6, 1023, 1'b1);
    cyc();
    checkVal("R6", "active ch1 via flag", actOf(1), 555);
    checkVal("R6", "active ch6 via flag", actOf(6), 1023);

    // R9 ignored pointer codes
    curReq = "R9";
    ptr(8'b011_00001); ptr(8'b000_00000); ptr(8'b111_11111); ptr(8'b010_01000);
    cyc();
    checkVal("R9", "active ch0 untouched", actOf(0), 100);

    // R8 single-channel reset
    curReq = "R8";
    ptr(8'b010_00101);
    cyc();
    checkVal("R8", "active ch5 reset", actOf(5), 512);
    checkVal("R8", "active ch4 kept", actOf(4), 248);

    // R11 reset wins over write to the same channel
    curReq = "R11";
    wrValid = 1'b1; wrChan = 3'd4; wrData = 10'd9; wrUpdate = 1'b1;
    ptrValid = 1'b1; ptrByte = 8'b010_00100;
    cyc();
    wrValid = 1'b0; wrUpdate = 1'b0; ptrValid = 1'b0;
    cyc();
    checkVal("R11", "active ch4", actOf(4), 512);

    // R7 all-channel reset with pin high
    curReq = "R7";
    ptr(8'b100_00000);
    cyc();
    checkVal("R7", "active ch6 reset", actOf(6), 512);

    // R2 general-call reset with pin high after fresh writes
    curReq = "R2";
    wr(2, 3, 1'b1);
    genResetReq = 1'b1; wrValid = 1'b1; wrChan = 3'd0; wrData = 10'd1;
    cyc();
    genResetReq = 1'b0; wrValid = 1'b0;
    cyc();
    checkVal("R2", "active ch2 reset", actOf(2), 512);

    // Mixed stimulus across all requirements
    curReq = "R3-mix";
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      wrValid = (r < 40); wrChan = 3'($urandom); wrData = W'($urandom);
      wrUpdate = ($urandom_range(0, 9) == 0);
      ptrValid = (r >= 90); ptrByte = 8'($urandom);
      genResetReq = (r == 89);
      if ($urandom_range(0, 15) == 0) loadPin = ~loadPin;
      rdChan = 3'($urandom);
      cyc();
    end
    wrValid = 1'b0; ptrValid = 1'b0; genResetReq = 1'b0;
    cyc(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule